// File: doc/BRIEF.md
# Infrared Remote-Control Frame Transmitter

This block turns one remote-control message into a pulse-distance waveform on a single active-high line. A one-cycle request captures a 16-bit address field, a 16-bit command field and two option bits. The block then plays out a fixed train of 34 symbols: a long leader mark and its space, then 32 data symbols, then a closing mark. After the closing mark the line goes back to low. Every data symbol starts with the same short mark. Its value is carried only by the length of the space that follows.

All durations are whole numbers of ticks. A tick comes from a clock prescaler that is restarted when a request is accepted, so every edge of the waveform falls a known number of clocks after the request. As an option, marks can be chopped by a 50% duty square wave at the carrier rate. A second option builds the address field from one byte and its bitwise complement. The host sees `busy_o` for the whole frame and a one-cycle `done_o` after the last mark.

Top module: `nec_ir_tx`

## Requirements
- R1: Out of reset, `ir_o`, `busy_o` and `done_o` are all 0, and `ir_o` stays 0 whenever `busy_o` is 0.
- R2: A request (`start_i` high while `busy_o` is 0) is taken at that clock edge. From the next cycle `busy_o` is 1 and the leader plays: a mark of floor(9000/TICK_US) ticks, then a space of floor(4500/TICK_US) ticks. One tick is CLK_PER_TICK clocks.
- R3: After the leader, 32 data symbols are sent. The 16 address-field bits go first, then the 16 command bits, each field least significant bit first. Every data symbol is a mark of floor(560/TICK_US) ticks. The space that follows is floor(1690/TICK_US) ticks for a 1 and floor(560/TICK_US) ticks for a 0.
- R4: After the last data symbol a closing mark of floor(560/TICK_US) ticks is sent, and the line then returns to 0.
- R5: With `inv_addr_i` = 1 the address field is {~addr_i[7:0], addr_i[7:0]}, and addr_i[15:8] has no effect. With `inv_addr_i` = 0 the address field is addr_i as given.
- R6: With `carrier_en_i` = 1, `ir_o` during a mark is a square wave. It starts at 1 in the first cycle of each mark and toggles every CARRIER_HALF_CLKS clocks. During spaces `ir_o` is 0. With `carrier_en_i` = 0, `ir_o` is a steady 1 for the whole mark.
- R7: `start_i` has no effect while `busy_o` is 1, including in the last cycle of the closing mark.
- R8: Address, command and both option inputs are captured at the accepting edge. Changes to them during a frame do not alter that frame.
- R9: `done_o` is 1 for exactly one cycle: the first cycle after the closing mark. `busy_o` falls to 0 in that same cycle and is 1 in every cycle of the frame.
- R10: A request raised in the cycle where `done_o` is 1 is accepted, and the next frame begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame request, taken only while idle |
| addr_i | input | 16 | Address field, or address byte in the low 8 bits |
| cmd_i | input | 16 | Command field |
| inv_addr_i | input | 1 | 1: build the address field from the low byte and its complement |
| carrier_en_i | input | 1 | 1: chop marks with the carrier square wave |
| ir_o | output | 1 | Infrared line, active high, idle low |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the closing mark |

## Verification
The end of one frame and the acceptance of the next can fall on the same cycle. The bench raises a new request in the exact cycle where `done_o` is high and expects the new leader mark one cycle later, with no idle gap and no lost pulse. The opposite edge is also provoked. A request held in the last cycle of the closing mark must be dropped, and the bench judges this by `busy_o` and `ir_o` staying low after the done pulse. Requests and input changes held during the early part of a frame are checked against the waveform built from the values captured at acceptance.

// File: rtl/nec_ir_tx_pkg.sv
// Package: shared constants and types for the infrared frame transmitter.
// Assumes: the durations are given in microseconds and converted to ticks by the
// user of the package.
package nec_ir_tx_pkg;

    // Nominal durations in microseconds
    localparam int LEAD_MARK_US  = 9000;
    localparam int LEAD_SPACE_US = 4500;
    localparam int BIT_MARK_US   = 560;
    localparam int ONE_SPACE_US  = 1690;
    localparam int ZERO_SPACE_US = 560;

    // Frame shape
    localparam int DATA_BITS = 32;
    localparam int SYMBOLS   = DATA_BITS + 2;
    localparam int SYM_W     = $clog2(SYMBOLS);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_MARK  = 2'd1,
        PH_SPACE = 2'd2
    } phase_t;

endpackage

// File: rtl/nec_tick_gen.sv
// Module: prescaler that gives one tick every CLK_PER_TICK clocks.
// Assumes: clear_i restarts the count, so the first tick after a clear falls
// CLK_PER_TICK clocks later. The counter holds while run_i is low.
module nec_tick_gen #(
    parameter int CLK_PER_TICK = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within a tick, wrapping at LAST
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/nec_carrier_gen.sv
// Module: 50% duty square wave with a restartable phase.
// Assumes: restart_i is high on the edge where a mark begins. After it the level
// is 1 and toggles every HALF_CLKS clocks.
module nec_carrier_gen #(
    parameter int HALF_CLKS = 1645
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic level_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    // Half-period counter and level toggle
    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level_o = lvl_q;

endmodule

// File: rtl/nec_frame_seq.sv
// Module: symbol sequencer. It walks leader, 32 data symbols and the closing
// mark, and counts each half symbol in ticks.
// Assumes: ticks come from a prescaler cleared on accept_o, and frame_i holds
// the 32 bits in send order (bit 0 first).
module nec_frame_seq
    import nec_ir_tx_pkg::*;
#(
    parameter int LEAD_MARK_T  = 900,
    parameter int LEAD_SPACE_T = 450,
    parameter int BIT_MARK_T   = 56,
    parameter int ONE_SPACE_T  = 169,
    parameter int ZERO_SPACE_T = 56
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] frame_i,
    input  logic                 tick_i,
    output logic                 busy_o,
    output logic                 mark_o,
    output logic                 done_o,
    output logic                 accept_o,
    output logic                 mark_begin_o
);
    localparam int DUR_W = $clog2(LEAD_MARK_T + 1);
    localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYMBOLS - 1);

    phase_t               phase_q;
    logic [SYM_W-1:0]     sym_q;
    logic [DUR_W-1:0]     dur_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 done_q;
    logic [DUR_W-1:0]     cur_len;
    logic                 half_end;

    // Length in ticks of the half symbol now playing
    always_comb begin
        cur_len = DUR_W'(BIT_MARK_T);
        if (phase_q == PH_MARK) begin
            cur_len = (sym_q == '0) ? DUR_W'(LEAD_MARK_T) : DUR_W'(BIT_MARK_T);
        end else if (phase_q == PH_SPACE) begin
            if (sym_q == '0) begin
                cur_len = DUR_W'(LEAD_SPACE_T);
            end else begin
                cur_len = shreg_q[0] ? DUR_W'(ONE_SPACE_T) : DUR_W'(ZERO_SPACE_T);
            end
        end
    end

    assign half_end     = tick_i && (dur_q == cur_len - 1'b1);
    assign accept_o     = start_i && (phase_q == PH_IDLE);
    assign mark_begin_o = accept_o || ((phase_q == PH_SPACE) && half_end);

    // Phase, symbol index, tick count and data shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            sym_q   <= '0;
            dur_q   <= '0;
            shreg_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept_o) begin
                        phase_q <= PH_MARK;
                        sym_q   <= '0;
                        dur_q   <= '0;
                        shreg_q <= frame_i;
                    end
                end
                PH_MARK: begin
                    if (half_end) begin
                        dur_q <= '0;
                        if (sym_q == LAST_SYM) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            phase_q <= PH_SPACE;
                        end
                    end else if (tick_i) begin
                        dur_q <= dur_q + 1'b1;
                    end
                end
                PH_SPACE: begin
                    if (half_end) begin
                        dur_q   <= '0;
                        phase_q <= PH_MARK;
                        sym_q   <= sym_q + 1'b1;
                        if (sym_q != '0) begin
                            shreg_q <= shreg_q >> 1;
                        end
                    end else if (tick_i) begin
                        dur_q <= dur_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o = (phase_q != PH_IDLE);
    assign mark_o = (phase_q == PH_MARK);
    assign done_o = done_q;

endmodule

// File: rtl/nec_ir_tx.sv
// Module: top of the infrared frame transmitter. It builds the 32-bit field,
// captures the options, and joins the prescaler, sequencer and carrier.
// Assumes: clk runs at CLK_PER_TICK * 1e6 / TICK_US Hz, and TICK_US divides the
// nominal durations closely enough for the target receiver.
module nec_ir_tx
    import nec_ir_tx_pkg::*;
#(
    parameter int CLK_PER_TICK      = 1250,
    parameter int TICK_US           = 10,
    parameter int CARRIER_HALF_CLKS = 1645
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [15:0] addr_i,
    input  logic [15:0] cmd_i,
    input  logic        inv_addr_i,
    input  logic        carrier_en_i,
    output logic        ir_o,
    output logic        busy_o,
    output logic        done_o
);
    localparam int LEAD_MARK_T  = LEAD_MARK_US  / TICK_US;
    localparam int LEAD_SPACE_T = LEAD_SPACE_US / TICK_US;
    localparam int BIT_MARK_T   = BIT_MARK_US   / TICK_US;
    localparam int ONE_SPACE_T  = ONE_SPACE_US  / TICK_US;
    localparam int ZERO_SPACE_T = ZERO_SPACE_US / TICK_US;

    logic [15:0]          addr_field;
    logic [DATA_BITS-1:0] frame_w;
    logic                 tick_w;
    logic                 busy_w;
    logic                 mark_w;
    logic                 accept_w;
    logic                 mark_begin_w;
    logic                 carrier_w;
    logic                 car_q;

    // Address field: given as-is, or low byte with its complement above
    always_comb begin
        if (inv_addr_i) begin
            addr_field = {~addr_i[7:0], addr_i[7:0]};
        end else begin
            addr_field = addr_i;
        end
    end

    assign frame_w = {cmd_i, addr_field};

    // Capture the carrier option when a frame is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car_q <= 1'b0;
        end else if (accept_w) begin
            car_q <= carrier_en_i;
        end
    end

    nec_tick_gen #(
        .CLK_PER_TICK(CLK_PER_TICK)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept_w),
        .run_i  (busy_w),
        .tick_o (tick_w)
    );

    nec_frame_seq #(
        .LEAD_MARK_T (LEAD_MARK_T),
        .LEAD_SPACE_T(LEAD_SPACE_T),
        .BIT_MARK_T  (BIT_MARK_T),
        .ONE_SPACE_T (ONE_SPACE_T),
        .ZERO_SPACE_T(ZERO_SPACE_T)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .frame_i     (frame_w),
        .tick_i      (tick_w),
        .busy_o      (busy_w),
        .mark_o      (mark_w),
        .done_o      (done_o),
        .accept_o    (accept_w),
        .mark_begin_o(mark_begin_w)
    );

    nec_carrier_gen #(
        .HALF_CLKS(CARRIER_HALF_CLKS)
    ) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(mark_begin_w),
        .level_o  (carrier_w)
    );

    assign ir_o   = mark_w && (!car_q || carrier_w);
    assign busy_o = busy_w;

endmodule

// File: rtl/nec_ir_tx_chk.sv
// Module: assertion checker for nec_ir_tx, attached by bind.
// Assumes: it sees the top ports plus the internal mark phase.
module nec_ir_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic ir_o,
    input logic busy_o,
    input logic done_o,
    input logic mark
);
    AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ir_o); // R1

    AST_ACCEPT_STARTS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && ir_o)); // R2

    AST_SPACE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mark) |-> !ir_o); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R9

    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mark) |=> busy_o); // R7
endmodule

bind nec_ir_tx nec_ir_tx_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .ir_o   (ir_o),
    .busy_o (busy_o),
    .done_o (done_o),
    .mark   (mark_w)
);

// File: tb/nec_ir_tx_test.sv
module nec_ir_tx_test;
    localparam int C  = 2;
    localparam int TU = 280;
    localparam int H  = 3;
    localparam int NH = 67;

    // Expected tick counts from the requirement formulas
    localparam int LM = 9000 / TU;
    localparam int LS = 4500 / TU;
    localparam int BM = 560 / TU;
    localparam int S1 = 1690 / TU;
    localparam int S0 = 560 / TU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] addr_i = '0;
    logic [15:0] cmd_i = '0;
    logic        inv_addr_i = 1'b0;
    logic        carrier_en_i = 1'b0;
    logic        ir_o, busy_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;
    int hl[NH];
    bit hm[NH];
    int total;

    always #4 clk = ~clk;

    nec_ir_tx #(
        .CLK_PER_TICK(C), .TICK_US(TU), .CARRIER_HALF_CLKS(H)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .cmd_i(cmd_i), .inv_addr_i(inv_addr_i), .carrier_en_i(carrier_en_i),
        .ir_o(ir_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected half-symbol list in clocks (R2, R3, R4, R5)
    task automatic build(input logic [15:0] a, input logic [15:0] c, input bit inv);
        logic [15:0] af;
        logic [31:0] bits;
        af = inv ? {~a[7:0], a[7:0]} : a;
        bits = {c, af};
        hl[0] = LM * C; hm[0] = 1;
        hl[1] = LS * C; hm[1] = 0;
        total = hl[0] + hl[1];
        for (int i = 0; i < 32; i++) begin
            hl[2 + 2*i] = BM * C;                   hm[2 + 2*i] = 1;
            hl[3 + 2*i] = (bits[i] ? S1 : S0) * C;  hm[3 + 2*i] = 0;
            total += hl[2 + 2*i] + hl[3 + 2*i];
        end
        hl[NH-1] = BM * C; hm[NH-1] = 1;
        total += hl[NH-1];
    endtask

    task automatic launch(input logic [15:0] a, input logic [15:0] c, input bit inv, input bit car);
        @(negedge clk);
        addr_i = a; cmd_i = c; inv_addr_i = inv; carrier_en_i = car; start_i = 1'b1;
    endtask

    // disturb: 0 none, 1 inputs changed and start held early (R7, R8), 2 start in last mark cycle (R7)
    task automatic track(input logic [15:0] a, input logic [15:0] c, input bit inv, input bit car,
                         input int disturb, input bit chain,
                         input logic [15:0] na, input logic [15:0] nc, input bit ninv, input bit ncar,
                         input string tag);
        int bad_ir = 0;
        int bad_bsy = 0;
        int first_k = -1;
        int act_v = 0;
        int exp_v = 0;
        int k = 0;
        bit e;
        build(a, c, inv);
        @(posedge clk);
        #1;
        if (disturb != 1) start_i = 1'b0;
        for (int h = 0; h < NH; h++) begin
            for (int j = 0; j < hl[h]; j++) begin
                @(negedge clk);
                if (disturb == 1 && k == 3) begin
                    addr_i = ~a; cmd_i = ~c; inv_addr_i = ~inv; carrier_en_i = ~car;
                end
                if (disturb == 1 && k == 40) start_i = 1'b0;
                if (disturb == 2 && k == total - 1) start_i = 1'b1;
                e = hm[h] && (!car || ((j / H) % 2 == 0));
                if (ir_o !== e) begin
                    bad_ir++;
                    if (first_k < 0) begin
                        first_k = k; act_v = int'(ir_o); exp_v = int'(e);
                    end
                end
                if (busy_o !== 1'b1 || done_o !== 1'b0) bad_bsy++;
                k++;
            end
        end
        if (bad_ir != 0)
            $display("FAIL %s: waveform first differs at cycle %0d, actual %0d expected %0d",
                     tag, first_k, act_v, exp_v);
        n_cmp++;
        if (bad_ir != 0) n_bad++;
        check(bad_bsy == 0, "R9 busy through frame", bad_bsy, 0);
        @(negedge clk);
        check(done_o === 1'b1 && busy_o === 1'b0 && ir_o === 1'b0, "R9 done at end",
              {done_o, busy_o, ir_o}, 3'b100);
        if (chain) begin
            addr_i = na; cmd_i = nc; inv_addr_i = ninv; carrier_en_i = ncar; start_i = 1'b1;
        end else begin
            start_i = 1'b0;
            @(negedge clk);
            check(done_o === 1'b0, "R9 done single cycle", int'(done_o), 0);
            check(busy_o === 1'b0 && ir_o === 1'b0, "R7 no late start", {busy_o, ir_o}, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected finish");
        n_cmp++;
        n_bad++;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] ra, rc;
        bit ri, rcar;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ir_o === 1'b0, "R1 ir after reset", int'(ir_o), 0);
        check(busy_o === 1'b0, "R1 busy after reset", int'(busy_o), 0);
        check(done_o === 1'b0, "R1 done after reset", int'(done_o), 0);

        // R2 R3 R4: all-zero and all-one frames
        launch(16'h0000, 16'h0000, 1'b0, 1'b0);
        track(16'h0000, 16'h0000, 1'b0, 1'b0, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R2 R3 R4 zeros");
        launch(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
        track(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R3 R4 ones");
        // R5: inverted address, high byte must not matter
        launch(16'hA53C, 16'h1234, 1'b1, 1'b0);
        track(16'hA53C, 16'h1234, 1'b1, 1'b0, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R5 inverted address");
        // R6: carrier on marks
        launch(16'h00F1, 16'h8E07, 1'b0, 1'b1);
        track(16'h00F1, 16'h8E07, 1'b0, 1'b1, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R6 carrier");
        // R7 R8: start held and inputs changed during frame
        launch(16'h5A11, 16'h0C3D, 1'b1, 1'b1);
        track(16'h5A11, 16'h0C3D, 1'b1, 1'b1, 1, 1'b0, '0, '0, 1'b0, 1'b0, "R7 R8 busy disturb");
        // R7: start in last mark cycle dropped
        launch(16'h2222, 16'h4444, 1'b0, 1'b0);
        track(16'h2222, 16'h4444, 1'b0, 1'b0, 2, 1'b0, '0, '0, 1'b0, 1'b0, "R7 late start");
        // R10: request in the done cycle chains the next frame
        launch(16'h0011, 16'h0001, 1'b1, 1'b0);
        track(16'h0011, 16'h0001, 1'b1, 1'b0, 0, 1'b1, 16'h0012, 16'h0002, 1'b1, 1'b1, "R10 first");
        track(16'h0012, 16'h0002, 1'b1, 1'b1, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R10 chained frame");

        // Random frames (R3 R5 R6)
        for (int n = 0; n < 6; n++) begin
            ra = 16'($urandom);
            rc = 16'($urandom);
            ri = 1'($urandom);
            rcar = 1'($urandom);
            launch(ra, rc, ri, rcar);
            track(ra, rc, ri, rcar, 0, 1'b0, '0, '0, 1'b0, 1'b0, "R3 R5 R6 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule